// File: doc/BRIEF.md
# Serial Port Bit-Clock Generator

This block produces the bit-rate timing for a serial port that runs either as an asynchronous receiver/transmitter or as a clock-synchronous shifter. A free-running prescaler derives three timing sources from the base clock: a full-rate or half-rate source, a divide-by-8 source, and a divide-by-32 source built from the divide-by-8 one. A two-bit select picks one of them. That source feeds a reloadable down-counter that divides by the loaded value plus one.

The serial mode field decides what follows the counter. In asynchronous modes a divide-by-16 stage gives a single bit tick that serves both the transmitter and the receiver. In synchronous modes with the internal clock, a toggle stage forms a 50% duty serial clock for the output pin and ticks the transmitter on its falling edges and the receiver on its rising edges. With the external clock chosen, the input pin is synchronized and edge-detected instead, and the internal chain is ignored. Every output tick is a one-cycle enable in the base clock domain.

Top module: `sio_bitclk_gen`

## Requirements
- R1: With source select 00b, the counter is fed every base cycle when `half_sel` is 0 and every second base cycle when `half_sel` is 1; with reload 0 in an asynchronous mode this gives bit ticks every 16 or 32 cycles.
- R2: Source select 01b feeds the counter once every 8 base cycles, and 10b once every 32 base cycles (a further divide by 4 after the divide by 8).
- R3: Source select 11b behaves exactly like 00b.
- R4: The counter emits one output for every n+1 source pulses, where n is the `reload` value.
- R5: In modes 100b, 101b and 110b, `tx_tick` and `rx_tick` pulse together, once every 16 counter outputs, and never in two consecutive cycles.
- R6: In modes 001b and 010b with `ext_sel` 0, `sclk_out` toggles on each counter output (equal high and low times); `tx_tick` pulses in the cycle `sclk_out` falls and `rx_tick` in the cycle it rises.
- R7: In modes 001b and 010b with `ext_sel` 1, `tx_tick` pulses once per falling edge and `rx_tick` once per rising edge of `ext_clk`, after a two-flop synchronizer; source select and reload have no effect and `sclk_out` stays high.
- R8: A new `reload` value is taken only when the counter reaches zero, so the period already running completes at its old length.
- R9: Modes 000b, 011b and 111b produce no ticks and hold `sclk_out` high.
- R10: During and right after reset, both ticks are low and `sclk_out` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_sel | input | 1 | Fastest source: 0 full rate, 1 half rate |
| src_sel | input | 2 | Source select: 00b/11b fast, 01b divide-by-8, 10b divide-by-32 |
| reload | input | DIV_W (8) | Counter reload value n (ratio n+1) |
| mode | input | 3 | Serial mode field |
| ext_sel | input | 1 | Synchronous modes: 1 uses `ext_clk` |
| ext_clk | input | 1 | External shift clock pin (asynchronous) |
| tx_tick | output | 1 | Transmit bit enable, one cycle wide |
| rx_tick | output | 1 | Receive bit enable, one cycle wide |
| sclk_out | output | 1 | Serial clock output level, idle high |

## Verification
A wrong prescaler or counter state shows up as a tick interval that differs from the expected product of source period, n+1 and the final ratio; the first wrong interval is visible one full bit period after the fault, at most 16 x 32 x 256 base cycles in the slowest setting. A wrong toggle state appears at once as unequal high and low times on `sclk_out` or a tick on the wrong edge, and a wrong reload capture appears as a half-period of a length that belongs to neither the old nor the new value. Disabled or external modes leaking the internal chain show up as ticks or a low `sclk_out` within one source period.

// File: rtl/sio_clk_pkg.sv
package sio_clk_pkg;

  typedef enum logic [1:0] {
    SRC_FAST  = 2'b00,
    SRC_DIV8  = 2'b01,
    SRC_DIV32 = 2'b10,
    SRC_ALT   = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    OP_OFF,
    OP_UART,
    OP_SYNC_INT,
    OP_SYNC_EXT
  } op_e;

  function automatic op_e decode_op(input logic [2:0] mode, input logic ext_sel);
    op_e op;
    case (mode)
      3'b100, 3'b101, 3'b110: op = OP_UART;
      3'b001, 3'b010:         op = ext_sel ? OP_SYNC_EXT : OP_SYNC_INT;
      default:                op = OP_OFF;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/sio_prescale.sv
module sio_prescale #(
  parameter int MID_RATIO  = 8,
  parameter int SLOW_RATIO = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_sel,
  input  logic [1:0] src_sel,
  output logic       src_tick
);
  import sio_clk_pkg::*;

  localparam int MW = (MID_RATIO  > 1) ? $clog2(MID_RATIO)  : 1;
  localparam int SW = (SLOW_RATIO > 1) ? $clog2(SLOW_RATIO) : 1;

  logic          half_q, half_n;
  logic [MW-1:0] mid_q, mid_n;
  logic [SW-1:0] slow_q, slow_n;
  logic          tick_q, tick_n;
  logic          t_fast, t_mid, t_slow;

  always_comb begin
    t_mid  = (mid_q == MW'(MID_RATIO - 1));
    t_slow = t_mid && (slow_q == SW'(SLOW_RATIO - 1));
    t_fast = half_sel ? half_q : 1'b1;

    half_n = ~half_q;
    mid_n  = t_mid ? '0 : mid_q + 1'b1;
    slow_n = slow_q;
    if (t_mid) slow_n = t_slow ? '0 : slow_q + 1'b1;

    case (src_e'(src_sel))
      SRC_DIV8:  tick_n = t_mid;
      SRC_DIV32: tick_n = t_slow;
      default:   tick_n = t_fast;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      mid_q  <= '0;
      slow_q <= '0;
      tick_q <= 1'b0;
    end else begin
      half_q <= half_n;
      mid_q  <= mid_n;
      slow_q <= slow_n;
      tick_q <= tick_n;
    end
  end

  assign src_tick = tick_q;
endmodule

// File: rtl/sio_reload_div.sv
module sio_reload_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic [DIV_W-1:0] reload,
  output logic             div_tick
);
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             tick_q, tick_n;
  logic             at_zero;

  always_comb begin
    at_zero = (cnt_q == '0);
    tick_n  = src_tick && at_zero;
    cnt_n   = cnt_q;
    if (src_tick) cnt_n = at_zero ? reload : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      tick_q <= tick_n;
    end
  end

  assign div_tick = tick_q;
endmodule

// File: rtl/sio_ext_edge.sv
module sio_ext_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[SYNC_STAGES-1:0], pin};
  end

  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign fall = ~sh_q[SYNC_STAGES-1] & sh_q[SYNC_STAGES];
endmodule

// File: rtl/sio_bit_stage.sv
module sio_bit_stage #(
  parameter int OVS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  sio_clk_pkg::op_e      op,
  input  logic                  div_tick,
  input  logic                  ext_rise,
  input  logic                  ext_fall,
  output logic                  tx_tick,
  output logic                  rx_tick,
  output logic                  sclk_out
);
  import sio_clk_pkg::*;

  localparam int OW = (OVS > 1) ? $clog2(OVS) : 1;

  logic [OW-1:0] ovs_q, ovs_n;
  logic          sclk_q, sclk_n;
  logic          tx_q, tx_n, rx_q, rx_n;

  always_comb begin
    ovs_n  = '0;
    sclk_n = 1'b1;
    tx_n   = 1'b0;
    rx_n   = 1'b0;
    case (op)
      OP_UART: begin
        ovs_n = ovs_q;
        if (div_tick) begin
          if (ovs_q == OW'(OVS - 1)) begin
            ovs_n = '0;
            tx_n  = 1'b1;
            rx_n  = 1'b1;
          end else begin
            ovs_n = ovs_q + 1'b1;
          end
        end
      end
      OP_SYNC_INT: begin
        sclk_n = sclk_q;
        if (div_tick) begin
          sclk_n = ~sclk_q;
          tx_n   = sclk_q;
          rx_n   = ~sclk_q;
        end
      end
      OP_SYNC_EXT: begin
        tx_n = ext_fall;
        rx_n = ext_rise;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovs_q  <= '0;
      sclk_q <= 1'b1;
      tx_q   <= 1'b0;
      rx_q   <= 1'b0;
    end else begin
      ovs_q  <= ovs_n;
      sclk_q <= sclk_n;
      tx_q   <= tx_n;
      rx_q   <= rx_n;
    end
  end

  assign tx_tick  = tx_q;
  assign rx_tick  = rx_q;
  assign sclk_out = sclk_q;
endmodule

// File: rtl/sio_bitclk_gen.sv
module sio_bitclk_gen #(
  parameter int DIV_W       = 8,
  parameter int MID_RATIO   = 8,
  parameter int SLOW_RATIO  = 4,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_sel,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] reload,
  input  logic [2:0]       mode,
  input  logic             ext_sel,
  input  logic             ext_clk,
  output logic             tx_tick,
  output logic             rx_tick,
  output logic             sclk_out
);
  import sio_clk_pkg::*;

  op_e  op;
  logic src_tick, div_tick, ext_rise, ext_fall;

  assign op = decode_op(mode, ext_sel);

  sio_prescale #(.MID_RATIO(MID_RATIO), .SLOW_RATIO(SLOW_RATIO)) u_pre (
    .clk(clk), .rst_n(rst_n), .half_sel(half_sel), .src_sel(src_sel),
    .src_tick(src_tick)
  );

  sio_reload_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .reload(reload),
    .div_tick(div_tick)
  );

  sio_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk(clk), .rst_n(rst_n), .pin(ext_clk), .rise(ext_rise), .fall(ext_fall)
  );

  sio_bit_stage #(.OVS(OVS)) u_bit (
    .clk(clk), .rst_n(rst_n), .op(op), .div_tick(div_tick),
    .ext_rise(ext_rise), .ext_fall(ext_fall),
    .tx_tick(tx_tick), .rx_tick(rx_tick), .sclk_out(sclk_out)
  );
endmodule

// File: rtl/sio_bitclk_gen_chk.sv
module sio_bitclk_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       ext_sel,
  input logic       tx_tick,
  input logic       rx_tick,
  input logic       sclk_out
);
  import sio_clk_pkg::*;

  logic is_off, is_uart, is_int;
  assign is_off  = (decode_op(mode, ext_sel) == OP_OFF);
  assign is_uart = (decode_op(mode, ext_sel) == OP_UART);
  assign is_int  = (decode_op(mode, ext_sel) == OP_SYNC_INT);

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (is_off && $past(is_off)) |-> (!tx_tick && !rx_tick));  // R9

  AST_UART_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (is_uart && $past(is_uart)) |-> (tx_tick == rx_tick));  // R5

  AST_UART_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (is_uart && tx_tick) |=> !tx_tick);  // R5

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_int && $past(!is_int)) |-> sclk_out);  // R7

  AST_FALL_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (is_int && $past(is_int) && $fell(sclk_out)) |-> (tx_tick && !rx_tick));  // R6

  AST_RISE_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (is_int && $past(is_int) && $rose(sclk_out)) |-> (rx_tick && !tx_tick));  // R6
endmodule

bind sio_bitclk_gen sio_bitclk_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .ext_sel(ext_sel),
  .tx_tick(tx_tick), .rx_tick(rx_tick), .sclk_out(sclk_out)
);

// File: tb/sim_sio_bitclk_gen.sv
module sim_sio_bitclk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_sel = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic [7:0] reload = 8'd0;
  logic [2:0] mode = 3'b000;
  logic       ext_sel = 1'b0;
  logic       ext_clk = 1'b0;
  wire        tx_tick, rx_tick, sclk_out;

  always #10 clk = ~clk;

  sio_bitclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .half_sel(half_sel), .src_sel(src_sel),
    .reload(reload), .mode(mode), .ext_sel(ext_sel), .ext_clk(ext_clk),
    .tx_tick(tx_tick), .rx_tick(rx_tick), .sclk_out(sclk_out)
  );

  int cyc;
  always @(posedge clk) cyc <= cyc + 1;

  // external pin: toggles every 7 cycles, always running
  int ext_cnt;
  always @(posedge clk) begin
    if (ext_cnt == 6) begin
      ext_cnt <= 0;
      ext_clk <= ~ext_clk;
    end else begin
      ext_cnt <= ext_cnt + 1;
    end
  end

  // scoreboard state
  int    exp_q[$];
  string cur_req = "";
  int    mon_sel;
  int    skip_req;
  bit    arm_tog;
  bit    arm_seen;
  int    skip_left;
  bit    have_last;
  int    last_cyc;
  logic  sclk_prev = 1'b1;
  bit    ev;
  int    itv;
  int    ev_exp;
  int    mon_chk, mon_err;
  int    drv_chk, drv_err;

  // monitor: measures intervals between selected events, pops expectations
  always @(negedge clk) begin
    if (arm_tog != arm_seen) begin
      arm_seen  = arm_tog;
      skip_left = skip_req;
      have_last = 1'b0;
    end
    case (mon_sel)
      0:       ev = tx_tick;
      1:       ev = (sclk_out !== sclk_prev);
      default: ev = rx_tick;
    endcase
    sclk_prev = sclk_out;
    if (rst_n && ev) begin
      if (have_last) begin
        itv = cyc - last_cyc;
        if (skip_left > 0) begin
          skip_left = skip_left - 1;
        end else if (exp_q.size() > 0) begin
          ev_exp  = exp_q.pop_front();
          mon_chk = mon_chk + 1;
          if (itv != ev_exp) begin
            mon_err = mon_err + 1;
            $display("FAIL %s interval act=%0d exp=%0d", cur_req, itv, ev_exp);
          end
        end
      end
      last_cyc  = cyc;
      have_last = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    drv_chk = drv_chk + 1;
    if (!ok) begin
      drv_err = drv_err + 1;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp_v);
    end
  endtask

  task automatic setup(input logic h, input logic [1:0] s, input logic [7:0] n,
                       input logic [2:0] m, input logic x);
    @(negedge clk);
    half_sel = h; src_sel = s; reload = n; mode = m; ext_sel = x;
  endtask

  // driver: arms the monitor and pushes the expected intervals
  task automatic expect_run(input string req, input int sel, input int skip,
                            input int val, input int cnt);
    cur_req  = req;
    mon_sel  = sel;
    skip_req = skip;
    arm_tog  = ~arm_tog;
    for (int i = 0; i < cnt; i++) exp_q.push_back(val);
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic quiet_window(input string req, input int len);
    int ticks = 0;
    int lows = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (tx_tick || rx_tick) ticks++;
      if (!sclk_out) lows++;
    end
    check(ticks == 0, {req, " ticks"}, ticks, 0);
    check(lows == 0, {req, " sclk_out low cycles"}, lows, 0);
  endtask

  bit timed_out;

  initial begin
    fork
      begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check(!tx_tick && !rx_tick, "R10 ticks in reset", {tx_tick, rx_tick}, 0);
        check(sclk_out === 1'b1, "R10 sclk_out in reset", sclk_out, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!tx_tick && !rx_tick && sclk_out, "R10 after release",
              {tx_tick, rx_tick, sclk_out}, 1);

        // R1: full-rate fast source, async mode 100b
        setup(1'b0, 2'b00, 8'd0, 3'b100, 1'b0);
        expect_run("R1 full-rate tx", 0, 2, 16, 3);
        expect_run("R5 rx matches tx", 2, 1, 16, 2);
        // R1: half-rate fast source
        setup(1'b1, 2'b00, 8'd0, 3'b100, 1'b0);
        expect_run("R1 half-rate tx", 0, 2, 32, 3);
        // R3: reserved select equals fast
        setup(1'b0, 2'b11, 8'd0, 3'b100, 1'b0);
        expect_run("R3 select 11b full-rate", 0, 2, 16, 3);
        setup(1'b1, 2'b11, 8'd0, 3'b110, 1'b0);
        expect_run("R3 select 11b half-rate", 0, 2, 32, 2);
        // R2: divide-by-8 and divide-by-32
        setup(1'b0, 2'b01, 8'd0, 3'b101, 1'b0);
        expect_run("R2 divide-by-8", 0, 2, 128, 2);
        setup(1'b0, 2'b10, 8'd1, 3'b110, 1'b0);
        expect_run("R2 divide-by-32 n=1", 2, 2, 1024, 2);
        // R4: reload ratio
        setup(1'b0, 2'b00, 8'd4, 3'b101, 1'b0);
        expect_run("R4 n=4 async", 0, 2, 80, 2);

        // R6: synchronous internal clock
        setup(1'b0, 2'b00, 8'd4, 3'b001, 1'b0);
        expect_run("R6 sclk half-period n=4", 1, 3, 5, 6);
        expect_run("R6 tx on falling n=4", 0, 1, 10, 3);
        expect_run("R6 rx on rising n=4", 2, 1, 10, 3);
        setup(1'b1, 2'b00, 8'd2, 3'b010, 1'b0);
        expect_run("R6 sclk half-period half-rate n=2", 1, 3, 6, 4);
        expect_run("R4 tx half-rate n=2", 0, 1, 12, 2);

        // R8: reload change mid-period
        setup(1'b0, 2'b00, 8'd9, 3'b001, 1'b0);
        expect_run("R8 old half-period", 1, 3, 10, 2);
        begin
          logic lvl;
          lvl = sclk_out;
          while (sclk_out === lvl) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        reload = 8'd1;
        cur_req = "R8 reload at zero";
        exp_q.push_back(10);
        for (int i = 0; i < 4; i++) exp_q.push_back(2);
        while (exp_q.size() > 0) @(negedge clk);

        // R7: external clock, reload and source irrelevant
        setup(1'b0, 2'b10, 8'd200, 3'b001, 1'b1);
        expect_run("R7 ext tx period", 0, 1, 14, 3);
        expect_run("R7 ext rx period", 2, 1, 14, 3);
        quiet_window_sclk: begin
          int lows = 0;
          for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!sclk_out) lows++;
          end
          check(lows == 0, "R7 sclk_out held high", lows, 0);
        end
        setup(1'b1, 2'b01, 8'd0, 3'b010, 1'b1);
        expect_run("R7 ext tx other config", 0, 1, 14, 2);

        // R9: disabled modes
        setup(1'b0, 2'b00, 8'd0, 3'b000, 1'b0);
        repeat (3) @(negedge clk);
        quiet_window("R9 mode 000b", 200);
        setup(1'b0, 2'b00, 8'd0, 3'b011, 1'b1);
        repeat (3) @(negedge clk);
        quiet_window("R9 mode 011b", 200);
        setup(1'b0, 2'b00, 8'd0, 3'b111, 1'b0);
        repeat (3) @(negedge clk);
        quiet_window("R9 mode 111b", 200);
      end
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) begin
      drv_chk = drv_chk + 1;
      drv_err = drv_err + 1;
      $display("FAIL watchdog %s act=%0d exp=%0d", cur_req, exp_q.size(), 0);
    end
    $display("CHECKS %0d ERRORS %0d", drv_chk + mon_chk, drv_err + mon_err);
    $finish;
  end
endmodule